// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire serial link to a 12-bit successive-approximation converter. The link has an active-low chip select, a serial clock that the block drives, and a data line that the block samples. A single-cycle start request opens one frame. The block lowers chip select while the serial clock is high, waits a setup interval, and runs exactly sixteen serial clock periods. It shifts in one bit per period, raises chip select after a hold interval, and then keeps the link idle for a quiet interval before it accepts another request.

Every frame is sixteen bits, most significant first. The first four bits must be zero and the last twelve carry the sample. The block presents the twelve data bits with a one-cycle valid strobe. If any of the four leading bits came back as one, it also raises a framing-error flag. All link timing comes from the system clock through parameter counts: the half-period of the serial clock, setup, hold and quiet. A parameter also picks the sampling instant inside the high phase. The late position, just before the next falling edge, gives the data line the most settling time.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, chip select and the serial clock are high and busy, result_valid and frame_err are low.
- R2: Chip select falls only while the serial clock is high, and the first serial clock falling edge comes exactly SETUP_CYC system cycles after chip select falls.
- R3: A frame holds exactly 16 serial clock rising edges, with the clock low for HALF_CYC system cycles in each period (16*HALF_CYC low cycles in all). The serial clock is high whenever chip select is high.
- R4: Chip select rises exactly HALF_CYC+HOLD_CYC system cycles after the last serial clock rising edge of the frame.
- R5: result_data[11] is the fifth bit received and result_data[0] is the sixteenth. Bit k of the frame is the value on the data line in the high phase of serial clock period k.
- R6: frame_err is 1 when any of the first four received bits is 1, and 0 otherwise. result_data still carries bits five to sixteen.
- R7: result_valid is high for exactly one system cycle per frame, in the cycle in which chip select rises. result_data and frame_err change only in that cycle.
- R8: Chip select stays high for at least QUIET_CYC+1 system cycles between frames. A start request while busy is high is ignored and starts no frame.
- R9: busy is high from the cycle after an accepted start until the quiet interval ends. If start is held high, the next frame is accepted after busy has been low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion readout |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or quiet interval in progress |
| result_data | output | 12 | Last received sample |
| result_valid | output | 1 | One-cycle strobe on result update |
| frame_err | output | 1 | A leading bit of the last frame was one |

## Verification
Two functions can fall in the same cycle. The end of one frame's quiet interval can coincide with a start request for the next frame. The bench holds start high across two frames. It requires busy to be low for exactly one cycle between them and chip select to be high for at least the quiet count. A second case lines up the framing-error flag with the result strobe. Frames with set leading bits are queued in the scoreboard next to clean frames, and flag and data are compared together on the strobe cycle. Start pulses placed inside a frame and inside its quiet interval must not produce an extra chip-select fall or an unexpected strobe.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_QUIET
  } link_st_t;

  function automatic int cnt_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (en) begin
      q <= {q[WIDTH-2:0], din};
    end
  end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_W      = 4,
  parameter int HALF_CYC    = 5,
  parameter int SETUP_CYC   = 3,
  parameter int HOLD_CYC    = 3,
  parameter int QUIET_CYC   = 12,
  parameter bit SAMPLE_LATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adc_sdo,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              busy,
  output logic [DATA_W-1:0] result_data,
  output logic              result_valid,
  output logic              frame_err
);

  localparam int FRAME_W = DATA_W + LEAD_W;
  localparam int MAX_CNT = cnt_max4(HALF_CYC, SETUP_CYC, HOLD_CYC, QUIET_CYC);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int BIT_W   = $clog2(FRAME_W);

  localparam logic [CNT_W-1:0] LD_HALF  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_QUIET = CNT_W'(QUIET_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  link_st_t st, st_nxt;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_done;
  logic             sh_clr;
  logic             sh_en;
  logic [FRAME_W-1:0] sh_q;
  logic [BIT_W-1:0] bit_idx;
  logic             bit_last;

  adc_rd_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .expired  (tmr_done)
  );

  adc_rd_shift #(.WIDTH(FRAME_W)) u_shift (
    .clk (clk),
    .rst (rst),
    .clr (sh_clr),
    .en  (sh_en),
    .din (adc_sdo),
    .q   (sh_q)
  );

  assign bit_last = (bit_idx == LAST_BIT);

  // Sampling instant inside the high phase: first or last system cycle
  generate
    if (SAMPLE_LATE) begin : g_late
      assign sh_en = (st == ST_HIGH) && tmr_done;
    end else begin : g_early
      assign sh_en = (st == ST_HIGH) && (tmr_cnt == LD_HALF);
    end
  endgenerate

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_clr   = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        st_nxt   = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = LD_SETUP;
        sh_clr   = 1'b1;
      end
      ST_SETUP: if (tmr_done) begin
        st_nxt   = ST_LOW;
        tmr_load = 1'b1;
        tmr_val  = LD_HALF;
      end
      ST_LOW: if (tmr_done) begin
        st_nxt   = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = LD_HALF;
      end
      ST_HIGH: if (tmr_done) begin
        tmr_load = 1'b1;
        if (bit_last) begin
          st_nxt  = ST_HOLD;
          tmr_val = LD_HOLD;
        end else begin
          st_nxt  = ST_LOW;
          tmr_val = LD_HALF;
        end
      end
      ST_HOLD: if (tmr_done) begin
        st_nxt   = ST_QUIET;
        tmr_load = 1'b1;
        tmr_val  = LD_QUIET;
      end
      ST_QUIET: if (tmr_done) begin
        st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      bit_idx      <= '0;
      adc_cs_n     <= 1'b1;
      adc_sclk     <= 1'b1;
      busy         <= 1'b0;
      result_data  <= '0;
      result_valid <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      st           <= st_nxt;
      busy         <= (st_nxt != ST_IDLE);
      result_valid <= 1'b0;
      if (sh_clr) begin
        bit_idx <= '0;
      end else if (st == ST_HIGH && tmr_done && !bit_last) begin
        bit_idx <= bit_idx + 1'b1;
      end
      if (st == ST_IDLE && st_nxt == ST_SETUP) adc_cs_n <= 1'b0;
      if (st == ST_HOLD && st_nxt == ST_QUIET) begin
        adc_cs_n     <= 1'b1;
        result_valid <= 1'b1;
        result_data  <= sh_q[DATA_W-1:0];
        frame_err    <= |sh_q[FRAME_W-1:DATA_W];
      end
      if (st_nxt == ST_LOW && st != ST_LOW) adc_sclk <= 1'b0;
      if (st_nxt == ST_HIGH && st != ST_HIGH) adc_sclk <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int QUIET_CYC = 12
) (
  input logic clk,
  input logic rst,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic busy,
  input logic result_valid
);

  localparam int QW = $clog2(QUIET_CYC + 2) + 1;
  localparam logic [QW-1:0] QLIM = QW'(QUIET_CYC + 1);

  logic [QW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= QLIM;
    end else if (!adc_cs_n) begin
      hi_run <= '0;
    end else if (hi_run < QLIM) begin
      hi_run <= hi_run + 1'b1;
    end
  end

  AST_CS_FALL_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> adc_sclk); // R2

  AST_CLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk); // R3

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid); // R7

  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $rose(adc_cs_n)); // R7

  AST_QUIET_KEPT: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> (hi_run >= QLIM)); // R8

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> !$past(busy)); // R8

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> busy); // R9

endmodule

bind adc_rd_ctrl adc_rd_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .adc_cs_n     (adc_cs_n),
  .adc_sclk     (adc_sclk),
  .busy         (busy),
  .result_valid (result_valid)
);

// File: tb/sim_adc_rd_ctrl.sv
`timescale 1ns/1ps
module sim_adc_rd_ctrl;

  localparam int HC = 2;
  localparam int SC = 2;
  localparam int HD = 2;
  localparam int QC = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sdo = 1'b0;
  logic cs_n, sclk, busy, valid, ferr;
  logic [11:0] rdata;

  int n_chk = 0;
  int n_err = 0;
  int cs_falls = 0;
  bit done = 1'b0;

  logic [15:0] word_q[$];
  logic [12:0] exp_q[$];

  always #2.5 clk = ~clk;

  adc_rd_ctrl #(
    .HALF_CYC(HC), .SETUP_CYC(SC), .HOLD_CYC(HD), .QUIET_CYC(QC)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .adc_sdo(sdo),
    .adc_cs_n(cs_n), .adc_sclk(sclk), .busy(busy),
    .result_data(rdata), .result_valid(valid), .frame_err(ferr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Converter model: bit 15 on chip-select fall, then one bit per falling edge from the second
  initial begin
    forever begin
      logic [15:0] w;
      int n;
      @(negedge cs_n);
      w = (word_q.size() != 0) ? word_q.pop_front() : 16'h0;
      n = 0;
      sdo = w[15];
      while (!cs_n) begin
        @(negedge sclk or posedge cs_n);
        if (!cs_n && !sclk) begin
          n++;
          if (n >= 2 && n <= 16) sdo = w[16-n];
        end
      end
    end
  end

  // Monitor: link timing and scoreboard
  initial begin
    logic p_cs, p_sclk, p_valid, first_fall;
    int since, rises, lows, last_rise, hi_cnt;
    p_cs = 1'b1; p_sclk = 1'b1; p_valid = 1'b0; first_fall = 1'b0;
    since = 0; rises = 0; lows = 0; last_rise = 0; hi_cnt = 1000;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      since++;
      if (p_cs && !cs_n) begin
        cs_falls++;
        check(sclk == 1'b1, "R2 sclk at cs fall", int'(sclk), 1);
        check(hi_cnt >= QC + 1, "R8 quiet length", hi_cnt, QC + 1);
        since = 0; rises = 0; lows = 0; first_fall = 1'b1; hi_cnt = 0;
      end
      if (!cs_n) begin
        if (!sclk) lows++;
        if (p_sclk && !sclk && first_fall) begin
          check(since == SC, "R2 setup cycles", since, SC);
          first_fall = 1'b0;
        end
        if (!p_sclk && sclk) begin
          rises++;
          last_rise = since;
        end
      end else begin
        if (hi_cnt < 1000) hi_cnt++;
      end
      if (!p_cs && cs_n) begin
        check(rises == 16, "R3 rising edges", rises, 16);
        check(lows == 16 * HC, "R3 low cycles", lows, 16 * HC);
        check(since - last_rise == HC + HD, "R4 hold", since - last_rise, HC + HD);
        check(valid == 1'b1, "R7 valid at cs rise", int'(valid), 1);
      end
      if (p_valid) check(!valid, "R7 valid width", int'(valid), 0);
      if (valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", int'(rdata), 0);
        end else begin
          logic [12:0] e;
          e = exp_q.pop_front();
          check(rdata == e[11:0], "R5 data", int'(rdata), int'(e[11:0]));
          check(ferr == e[12], "R6 frame_err", int'(ferr), int'(e[12]));
        end
      end
      p_cs = cs_n; p_sclk = sclk; p_valid = valid;
    end
  end

  task automatic push_word(input logic [15:0] w);
    word_q.push_back(w);
    exp_q.push_back({|w[15:12], w[11:0]});
  endtask

  task automatic run_frame(input logic [15:0] w, input bit poke);
    push_word(w);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      while (cs_n == 1'b0) @(negedge clk);
      repeat (2) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int falls0, gap;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b1, "R1 link idle in reset", {cs_n, sclk}, 3);
    check(!busy && !valid && !ferr, "R1 flags low in reset", {busy, valid, ferr}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(cs_n && sclk && !busy && !valid, "R1 after reset", {cs_n, sclk, busy, valid}, 4'hc);

    run_frame(16'h0ABC, 1'b0);
    run_frame(16'h0FFF, 1'b0);
    run_frame(16'h0000, 1'b0);
    run_frame(16'h0555, 1'b0);
    run_frame(16'hF123, 1'b0);
    run_frame(16'h8000, 1'b0);
    run_frame(16'h1FFF, 1'b0);

    falls0 = cs_falls;
    run_frame(16'h0321, 1'b1);
    repeat (40) @(negedge clk);
    check(cs_falls == falls0 + 1, "R8 start ignored while busy", cs_falls - falls0, 1);
    check(exp_q.size() == 0, "R8 no extra result", exp_q.size(), 0);

    push_word(16'h0AAA);
    push_word(16'h2F0F);
    start = 1'b1;
    @(negedge clk);
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    gap = 0;
    while (!busy) begin gap++; @(negedge clk); end
    start = 1'b0;
    check(gap == 1, "R9 back-to-back idle gap", gap, 1);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9 both results seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule